// File: doc/BRIEF.md
# Circular FIFO with Direction Flag

This block is a single-clock first-in first-out buffer between a producer and a consumer. The storage is a dual-port synchronous RAM with one write port and one registered read port. Two independent address counters select the locations. The write counter moves on every accepted write, and the read counter moves on every accepted read. Both counters wrap at the buffer depth, so the storage is used as a ring.

The two counters are equal both when the ring is empty and when it is full. A one-bit direction state machine tells these two cases apart by remembering whether the last change in occupancy was a gain or a loss. The full and empty flags are the equality signal qualified by that state.

A write that arrives while the buffer is full is dropped, and so is a read that arrives while it is empty. Neither one moves a counter or changes the direction state. Read data appears on the clock edge that accepts the read and is held until the next accepted read.

Top module: `circ_fifo_dirflag`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0 and `rd_data` is 0.
- R2: With the default 8-bit addresses the buffer holds 256 entries. Starting from empty, `full` stays 0 after 255 writes and goes to 1 after the 256th write.
- R3: Data is read out in exactly the order it was accepted, including across the wrap of either counter.
- R4: An accepted read presents the oldest entry on `rd_data` one cycle after `rd_en` was sampled. `rd_data` keeps its value in every cycle without an accepted read.
- R5: An accepted write with no accepted read in the same cycle puts the controller in the filling direction, so `empty` is 0 afterwards.
- R6: An accepted read with no accepted write in the same cycle puts the controller in the emptying direction, so `full` is 0 afterwards.
- R7: When an accepted write and an accepted read happen in the same cycle, or when neither happens, the direction and both flags are unchanged.
- R8: `full` is 1 exactly when the counters are equal and the direction is filling. `empty` is 1 exactly when the counters are equal and the direction is emptying. The two flags are never 1 together.
- R9: A write while `full` is 1 is ignored. The stored contents, the count and the flags are as if the write had not been issued, and this holds even when a read is accepted in the same cycle.
- R10: A read while `empty` is 1 is ignored. `rd_data` keeps its value and `empty` stays 1. A write in the same cycle is still accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write request |
| wr_data | input | 8 | Data to store on an accepted write |
| rd_en | input | 1 | Read request |
| rd_data | output | 8 | Registered read data |
| full | output | 1 | Buffer holds 256 entries |
| empty | output | 1 | Buffer holds no entries |

## Verification
The bench goes after the cases where the counters become equal. One is the 256th write, where a design with a wrong direction update would raise `empty` instead of `full`. The other is the last read, where a stale direction would report full. Requests against a full or an empty buffer are driven both alone and together with the opposite request. A design that lets a dropped write through would overwrite the oldest entry and corrupt the read order, and a design that honours a dropped read would change `rd_data`. Long stretches of concurrent reads and writes with random gaps move both counters across the wrap, which exposes any counter that wraps early or a direction that flips on a balanced cycle.

// File: rtl/fifo_dir_pkg.sv
package fifo_dir_pkg;

  // Direction memory for the equal-pointer case
  typedef enum logic {
    DIR_DRAIN = 1'b0,
    DIR_FILL  = 1'b1
  } fifo_dir_e;

  localparam int unsigned FIFO_ADDR_W_DEF = 8;
  localparam int unsigned FIFO_DATA_W_DEF = 8;

endpackage

// File: rtl/fifo_rst_sync.sv
module fifo_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/fifo_addr_ctr.sv
module fifo_addr_ctr #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [WIDTH-1:0] addr
);

  logic [WIDTH-1:0] addr_d;

  always_comb begin
    addr_d = addr;
    if (step) addr_d = addr + {{(WIDTH-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr <= '0;
    else        addr <= addr_d;
  end

  // R2 / R3: pointer advances by one (mod depth) only when enabled
  assert_ctr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> addr == $past(addr) + {{(WIDTH-1){1'b0}}, 1'b1});
  assert_ctr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(addr));

endmodule

// File: rtl/fifo_dp_ram.sv
module fifo_dp_ram #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Storage array: no reset, write port only
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read port with clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end

  // R4: output register only changes on an enabled read
  assert_rdata_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !re |=> $stable(rdata));

endmodule

// File: rtl/fifo_dir_fsm.sv
module fifo_dir_fsm
  import fifo_dir_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic pop,
  output fifo_dir_e dir
);

  fifo_dir_e dir_d;

  always_comb begin
    dir_d = dir;
    unique case ({push, pop})
      2'b10:   dir_d = DIR_FILL;
      2'b01:   dir_d = DIR_DRAIN;
      default: dir_d = dir;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir <= DIR_DRAIN;
    else        dir <= dir_d;
  end

  assert_dir_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> dir == DIR_FILL);
  assert_dir_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> dir == DIR_DRAIN);
  assert_dir_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push == pop) |=> $stable(dir));

endmodule

// File: rtl/circ_fifo_dirflag.sv
module circ_fifo_dirflag
  import fifo_dir_pkg::*;
#(
  parameter int unsigned ADDR_W = FIFO_ADDR_W_DEF,
  parameter int unsigned DATA_W = FIFO_DATA_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              full,
  output logic              empty
);

  logic              rst_n_int;
  logic [ADDR_W-1:0] wr_ptr;
  logic [ADDR_W-1:0] rd_ptr;
  logic              ptr_eq;
  logic              push_ok;
  logic              pop_ok;
  fifo_dir_e         dir;

  fifo_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  // Requests gated by the flags: overflow and underflow are dropped
  assign push_ok = wr_en && !full;
  assign pop_ok  = rd_en && !empty;

  fifo_addr_ctr #(.WIDTH(ADDR_W)) u_wr_ctr (
    .clk   (clk),
    .rst_n (rst_n_int),
    .step  (push_ok),
    .addr  (wr_ptr)
  );

  fifo_addr_ctr #(.WIDTH(ADDR_W)) u_rd_ctr (
    .clk   (clk),
    .rst_n (rst_n_int),
    .step  (pop_ok),
    .addr  (rd_ptr)
  );

  fifo_dp_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk   (clk),
    .rst_n (rst_n_int),
    .we    (push_ok),
    .waddr (wr_ptr),
    .wdata (wr_data),
    .re    (pop_ok),
    .raddr (rd_ptr),
    .rdata (rd_data)
  );

  fifo_dir_fsm u_dir (
    .clk   (clk),
    .rst_n (rst_n_int),
    .push  (push_ok),
    .pop   (pop_ok),
    .dir   (dir)
  );

  assign ptr_eq = (wr_ptr == rd_ptr);
  assign full   = ptr_eq && (dir == DIR_FILL);
  assign empty  = ptr_eq && (dir == DIR_DRAIN);

  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n_int)
    !(full && empty));
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n_int)
    (wr_en && full) |=> wr_ptr == $past(wr_ptr));
  assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n_int)
    (rd_en && empty) |=> $stable(rd_data) && rd_ptr == $past(rd_ptr));
  assert_fill_clears_empty_R5: assert property (@(posedge clk) disable iff (!rst_n_int)
    (push_ok && !pop_ok) |=> !empty);

endmodule

// File: tb/sim_circ_fifo_dirflag.sv
module sim_circ_fifo_dirflag;

  localparam int DEPTH = 256;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       rd_en;
  logic [7:0] rd_data;
  logic       full;
  logic       empty;

  always #10 clk = ~clk;

  circ_fifo_dirflag u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .full    (full),
    .empty   (empty)
  );

  int        n_checks = 0;
  int        n_errors = 0;
  bit        done     = 1'b0;
  logic [7:0] model_q[$];
  logic [7:0] exp_rd;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  // One clock: drive at negedge, update model at posedge, compare at next negedge
  task automatic step(input bit we, input logic [7:0] wd, input bit re);
    bit m_full, m_empty;
    wr_en   = we;
    wr_data = wd;
    rd_en   = re;
    m_full  = (model_q.size() == DEPTH);
    m_empty = (model_q.size() == 0);
    @(posedge clk);
    if (re && !m_empty) exp_rd = model_q.pop_front();
    if (we && !m_full)  model_q.push_back(wd);
    @(negedge clk);
    check("R3 R4 rd_data", rd_data, exp_rd);
    check("R8 full", full, model_q.size() == DEPTH);
    check("R8 empty", empty, model_q.size() == 0);
  endtask

  initial begin
    #(20 * 200000);
    n_errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [7:0] snap;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    exp_rd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1
    check("R1 empty", empty, 1);
    check("R1 full", full, 0);
    check("R1 rd_data", rd_data, 0);

    // R10: read on empty, alone
    step(0, 8'h00, 1);
    check("R10 empty stays", empty, 1);
    check("R10 rd_data held", rd_data, 0);

    // R10: read and write on empty together, write is kept
    step(1, 8'h3C, 1);
    check("R10 write kept", empty, 0);
    check("R10 rd_data held", rd_data, 0);
    step(0, 8'h00, 1);
    check("R4 first word", rd_data, 8'h3C);

    // R5 then R6
    step(1, 8'hA5, 0);
    check("R5 empty low", empty, 0);
    step(0, 8'h00, 1);
    check("R4 read value", rd_data, 8'hA5);
    check("R6 empty back", empty, 1);

    // R7: balanced traffic at occupancy 3 and idle cycles
    for (int i = 0; i < 3; i++) step(1, 8'(8'h10 + i), 0);
    for (int i = 0; i < 20; i++) begin
      step(1, 8'(8'h40 + i), 1);
      check("R7 empty unchanged", empty, 0);
      check("R7 full unchanged", full, 0);
    end
    step(0, 8'h00, 0);
    snap = rd_data;
    step(0, 8'h00, 0);
    check("R4 idle hold", rd_data, snap);
    while (model_q.size() != 0) step(0, 8'h00, 1);
    check("R6 drained", empty, 1);

    // R2: fill to depth
    for (int i = 0; i < DEPTH; i++) begin
      step(1, 8'(i * 7 + 3), 0);
      if (i == DEPTH - 2) check("R2 not full at 255", full, 0);
    end
    check("R2 full at 256", full, 1);
    check("R8 not empty when full", empty, 0);

    // R9: write while full, alone and with a read
    step(1, 8'hEE, 0);
    check("R9 full stays", full, 1);
    step(1, 8'hEF, 1);
    check("R9 first out", rd_data, 8'h03);
    check("R9 dropped write, not full", full, 0);
    step(1, 8'h77, 0);
    check("R5 full again", full, 1);

    // R3: drain and compare order (model carries the expected order)
    while (model_q.size() != 0) step(0, 8'h00, 1);
    check("R3 last word", rd_data, 8'h77);
    check("R6 empty after drain", empty, 1);

    // R3 / R7: random mixed traffic across many wraps
    for (int i = 0; i < 4000; i++) begin
      bit w, r;
      w = ($urandom_range(0, 99) < ((i / 500) % 2 == 0 ? 70 : 35));
      r = ($urandom_range(0, 99) < ((i / 500) % 2 == 0 ? 35 : 70));
      step(w, 8'($urandom), r);
    end

    finish_run();
  end

endmodule